// File: doc/BRIEF.md
# Multi-Channel UART Baud Rate Generator

This block derives the sampling and bit timing for a set of independent asynchronous serial channels from one peripheral clock. Each channel holds an 8-bit divisor value N and a small control register. The control register has a 2-bit prescale select n, which divides the clock by 1, 4, 16 or 64. It also has a double-speed bit and an oversampling select that picks 16x or 8x.

The divider chain has three stages. First comes a power-of-four prescaler. Next is an (N+1) down-counter. The last stage divides by two, and double speed skips it. The chain produces a one-cycle base enable at the oversampling rate. A second counter turns the base enable into a one-cycle bit enable, once per 16 or 8 base enables. All outputs are single-cycle enables in the clock domain, and the block creates no derived clocks.

A host loads and reads back the settings through a plain write/read port that selects a channel and one of two registers. Any write to a channel restarts that channel's whole chain at once. The new rate therefore begins from a clean phase on the next cycle, and the other channels are not disturbed.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset every channel reads N = 0xFF and control = 0x00, and no enable is asserted while reset is held.
- R2: Address 0 is N (8 bits). Address 1 is the control register: bits [1:0] are prescale select n, bit 2 is double speed and bit 3 is 8x oversampling. Both registers read back what was written, except that control bits [7:4] always read as zero.
- R3: In normal speed with 16x oversampling, base_en pulses once every D = 2 × 4^n × (N+1) cycles, for every n from 0 to 3.
- R4: With bit 3 of control set, bit_en pulses on every 8th base enable. With it clear, bit_en pulses on every 16th base enable.
- R5: With bit 2 of control set, the divide-by-two stage is skipped, so D = 4^n × (N+1).
- R6: With N = 0, n = 0 and double speed, base_en is high on every cycle.
- R7: After a write to a channel, that channel's counters restart. The first base_en comes D−1 cycles after the write edge, and the first bit_en comes 8·D−1 or 16·D−1 cycles after it.
- R8: A write to one channel leaves the registers and the enable timing of every other channel unchanged.
- R9: A read of a channel index at or above NUM_CH returns zero, and a write to such an index changes no channel.
- R10: bit_en is asserted only in a cycle where base_en of the same channel is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| ch_i | input | CH_W | Channel select for the write and the read |
| addr_i | input | 1 | Register select: 0 = N, 1 = control |
| wdata_i | input | RATE_W | Write data |
| rdata_o | output | RATE_W | Read data for the selected channel and register |
| base_en_o | output | NUM_CH | Per-channel base (oversampling) enable |
| bit_en_o | output | NUM_CH | Per-channel bit-rate enable |

## Verification
The bench builds the block with NUM_CH = 3 and RATE_W = 8. Three channels can run different rates at the same time while the host writes to only one of them. Because the channel select is 2 bits wide, index 3 is a channel that does not exist. Small N values keep the periods short enough to cover every prescale select, including the divide-by-64 case, and both oversampling ratios with the double-speed bit on and off. The same setting also reaches the every-cycle case at N = 0.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int CKS_W  = 2;
  localparam int CTRL_W = CKS_W + 2;

  typedef enum logic {
    REG_RATE = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic             os8;
    logic             dbl;
    logic [CKS_W-1:0] cks;
  } ctrl_t;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int CKS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             tick_o
);
  localparam int PRE_W = 2 * ((1 << CKS_W) - 1);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  // divide by 4^cks
  always_comb lim = PRE_W'((33'd1 << {cks_i, 1'b0}) - 33'd1);
  assign tick_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3
  pre_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cks_i == '0) |-> tick_o);

  // R3
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RATE_W-1:0] reload_val_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              tick_i,
  input  logic              dbl_i,
  output logic              base_o
);
  logic [RATE_W-1:0] cnt_q;
  logic              half_q;
  logic              div_tick;

  assign div_tick = tick_i && (cnt_q == '0);
  // double speed skips the divide-by-two stage
  assign base_o   = div_tick && (dbl_i || half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      half_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= reload_val_i;
      half_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == '0) ? rate_i : cnt_q - 1'b1;
      if (div_tick) half_q <= ~half_q;
    end
  end

  // R7
  div_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(reload_val_i)));

  // R3
  base_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_i && base_o && !load_i) |=> !base_o);
endmodule

// File: rtl/baud_oversample.sv
module baud_oversample #(
  parameter int OS_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic base_i,
  input  logic os8_i,
  output logic bit_o
);
  logic [OS_W-1:0] cnt_q;
  logic [OS_W-1:0] lim;

  assign lim   = os8_i ? OS_W'((1 << (OS_W - 1)) - 1) : '1;
  assign bit_o = base_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (base_i) cnt_q <= bit_o ? '0 : cnt_q + 1'b1;
  end

  // R10
  bit_on_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> base_i);

  // R4
  os_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    os8_i |-> (cnt_q < OS_W'(1 << (OS_W - 1))));

  // R4
  os_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_o && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/baud_channel.sv
module baud_channel
  import baud_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [RATE_W-1:0] wdata_i,
  output logic [RATE_W-1:0] rdata_o,
  output logic              base_en_o,
  output logic              bit_en_o
);
  logic [RATE_W-1:0] rate_q;
  ctrl_t             ctrl_q;
  logic [RATE_W-1:0] reload_val;
  logic              tick;
  logic              wr_rate;
  logic              wr_ctrl;

  assign wr_rate = wr_en_i && (addr_i == REG_RATE);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '1;
      ctrl_q <= '0;
    end else begin
      if (wr_rate) rate_q <= wdata_i;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // any write restarts the chain with the value that will be live next cycle
  assign reload_val = wr_rate ? wdata_i : rate_q;

  always_comb begin
    if (addr_i == REG_RATE) rdata_o = rate_q;
    else                    rdata_o = {{(RATE_W-CTRL_W){1'b0}}, ctrl_q};
  end

  baud_prescaler #(.CKS_W(CKS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_en_i),
    .cks_i  (ctrl_q.cks),
    .tick_o (tick)
  );

  baud_divider #(.RATE_W(RATE_W)) u_div (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (wr_en_i),
    .reload_val_i (reload_val),
    .rate_i       (rate_q),
    .tick_i       (tick),
    .dbl_i        (ctrl_q.dbl),
    .base_o       (base_en_o)
  );

  baud_oversample #(.OS_W(4)) u_os (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_en_i),
    .base_i (base_en_o),
    .os8_i  (ctrl_q.os8),
    .bit_o  (bit_en_o)
  );

  // R2
  rate_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rate |=> (rate_q == $past(wdata_i)));

  // R6
  every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.dbl && ctrl_q.cks == '0 && rate_q == '0 && !wr_en_i) |=> base_en_o);
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int NUM_CH = 2,
  parameter int RATE_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              addr_i,
  input  logic [RATE_W-1:0] wdata_i,
  output logic [RATE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] base_en_o,
  output logic [NUM_CH-1:0] bit_en_o
);
  logic [NUM_CH-1:0] wr_vec;
  logic [RATE_W-1:0] rd_arr [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_vec[g] = wr_en_i && (ch_i == CH_W'(g));

    baud_channel #(.RATE_W(RATE_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_vec[g]),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .rdata_o   (rd_arr[g]),
      .base_en_o (base_en_o[g]),
      .bit_en_o  (bit_en_o[g])
    );
  end

  // unmapped channel index reads zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ch_i == CH_W'(i)) rdata_o = rd_arr[i];
  end

  // R8
  chan_wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));

  // R10
  bit_base_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_o & ~base_en_o) == '0);
endmodule

// File: tb/uart_baud_gen_test.sv
`timescale 1ns/1ps
module uart_baud_gen_test;
  localparam int NCH = 3;
  localparam int RW  = 8;
  localparam int CW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [CW-1:0] ch = '0;
  logic          addr = 1'b0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic [NCH-1:0] base_en, bit_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase_tag = "R1";

  int rate_m [NCH];
  int ctl_m  [NCH];
  int cyc_m  [NCH];

  always #2 clk = ~clk;

  uart_baud_gen #(.NUM_CH(NCH), .RATE_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .ch_i(ch), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .base_en_o(base_en), .bit_en_o(bit_en)
  );

  function automatic int divisor(int c);
    int n = ctl_m[c] & 3;
    int d = (rate_m[c] + 1) * (1 << (2 * n));
    if (((ctl_m[c] >> 2) & 1) == 0) d = d * 2;
    return d;
  endfunction

  function automatic int ovs(int c);
    return ((ctl_m[c] & 8) != 0) ? 8 : 16;
  endfunction

  function automatic string mode_tag(int c);
    if (divisor(c) == 1)         return "R6";
    if ((ctl_m[c] & 4) != 0)     return "R5";
    if ((ctl_m[c] & 8) != 0)     return "R4";
    return "R3";
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        rate_m[c] = 255; ctl_m[c] = 0; cyc_m[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wr_en && int'(ch) == c) begin
          if (addr == 1'b0) rate_m[c] = int'(wdata);
          else              ctl_m[c]  = int'(wdata) & 15;
          cyc_m[c] = 0;
        end else begin
          cyc_m[c] = cyc_m[c] + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        logic eb, ebit;
        if (!rst_n) begin
          eb = 1'b0; ebit = 1'b0;
        end else begin
          eb   = ((cyc_m[c] + 1) % divisor(c)) == 0;
          ebit = ((cyc_m[c] + 1) % (divisor(c) * ovs(c))) == 0;
        end
        checks++;
        if (base_en[c] !== eb) begin
          fails++;
          $display("FAIL %s/%s ch%0d base_en actual %b expected %b t=%0t",
                   mode_tag(c), phase_tag, c, base_en[c], eb, $time);
        end
        checks++;
        if (bit_en[c] !== ebit) begin
          fails++;
          $display("FAIL R10/%s/%s ch%0d bit_en actual %b expected %b t=%0t",
                   mode_tag(c), phase_tag, c, bit_en[c], ebit, $time);
        end
      end
    end
  end

  task automatic wr(int c, int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; ch = CW'(c); addr = a[0]; wdata = RW'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(int c, int a, int expv, string tag);
    @(posedge clk); #1;
    ch = CW'(c); addr = a[0];
    #0.5;
    checks++;
    if (rdata !== RW'(expv)) begin
      fails++;
      $display("FAIL %s read ch%0d addr%0d actual %0h expected %0h", tag, c, a, rdata, expv);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    phase_tag = "R1";
    idle(3);
    for (int c = 0; c < NCH; c++) begin
      rd(c, 0, 8'hFF, "R1");
      rd(c, 1, 8'h00, "R1");
    end
    @(posedge clk); #1 rst_n = 1'b1;
    phase_tag = "R3";
    idle(600);

    // R2 readback, upper control bits dropped
    phase_tag = "R2";
    wr(0, 0, 3);
    wr(0, 1, 8'hF0);
    rd(0, 1, 8'h00, "R2");
    rd(0, 0, 8'h03, "R2");
    wr(1, 1, 8'hAB);
    rd(1, 1, 8'h0B, "R2");

    // R3 normal 16x, several prescales
    phase_tag = "R3";
    wr(1, 0, 1);
    wr(1, 1, 8'h01);
    idle(600);
    wr(2, 0, 0);
    wr(2, 1, 8'h02);
    idle(1100);

    // R4 8x oversampling
    phase_tag = "R4";
    wr(1, 1, 8'h09);
    wr(0, 1, 8'h08);
    idle(400);

    // R5 double speed, including divide by 64
    phase_tag = "R5";
    wr(0, 0, 2);
    wr(0, 1, 8'h05);
    wr(1, 0, 0);
    wr(1, 1, 8'h07);
    idle(1100);

    // R6 every-cycle enable
    phase_tag = "R6";
    wr(2, 0, 0);
    wr(2, 1, 8'h04);
    idle(40);
    wr(2, 1, 8'h0C);
    idle(40);

    // R7 restart mid-period with odd gaps
    phase_tag = "R7";
    wr(0, 0, 1);
    wr(0, 1, 8'h00);
    for (int k = 1; k < 8; k++) begin
      idle(3 * k + 1);
      wr(0, 0, 1);
    end
    idle(100);

    // R8 writes to other channels do not disturb channel 0
    phase_tag = "R8";
    wr(0, 0, 4);
    wr(0, 1, 8'h08);
    for (int k = 0; k < 6; k++) begin
      idle(7);
      wr(1, 0, k);
      wr(2, 1, k & 15);
    end
    idle(200);
    rd(0, 0, 8'h04, "R8");
    rd(0, 1, 8'h08, "R8");

    // R9 nonexistent channel
    phase_tag = "R9";
    wr(3, 0, 8'h55);
    wr(3, 1, 8'h0F);
    rd(3, 0, 8'h00, "R9");
    rd(3, 1, 8'h00, "R9");
    rd(0, 0, 8'h04, "R9");
    rd(1, 0, 8'h05, "R9");
    rd(2, 1, 8'h05, "R9");
    idle(200);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule